// File: doc/BRIEF.md
# Dual-Issue Bypassed Integer Register File

This block is the general register file for a core that issues two integer operations per cycle into two parallel pipes, called pipe A and pipe B. It stores 32 registers of 64 bits. Each pipe owns one write port and two read ports, so the file has four read ports and two write ports. Register 0 is a constant zero. Writes to it are dropped, and it never takes a forwarded value.

Each read port resolves its operand from the newest producer of the requested register. The candidates, from highest to lowest priority, are:
- the execute-stage result of either pipe;
- the writeback-stage result of either pipe;
- a write landing in the same cycle;
- the stored array.

Within one stage, a per-stage order bit says which pipe holds the later instruction in program order, and that pipe wins. Forwarding works within a pipe and across the two pipes. Every read port can see every source.

Read indices and forwarding inputs are sampled together at a rising clock edge. The resolved operands appear on registered outputs right after that edge.

Top module: `dual_rf_bypass`

## Requirements
- R1: While `rst` is high at a rising edge, every read-data lane is cleared to zero after that edge.
- R2: A read of index 0 returns zero, even when a valid forwarding source or a write names index 0. A write to index 0 changes nothing.
- R3: A write presented with `wr_x_en`=1 at a rising edge is stored. A read presented at a later edge returns it in the read lane after that edge, with one edge of latency.
- R4: The four read ports are independent. Read port k uses `rd_idx[5k+4:5k]` and drives `rd_data[64k+63:64k]`.
- R5: If both write ports target the same nonzero register in one cycle, the stored value is pipe B's data when `wr_b_late`=1 and pipe A's data when `wr_b_late`=0.
- R6: A read of a register being written in the same cycle returns the new data. If both ports write it, the rule of R5 picks the data.
- R7: Forwarding priority is: execute-stage sources, then writeback-stage sources, then same-cycle writes, then the stored array.
- R8: When both execute sources match, pipe B's value is taken if `ex_b_late`=1, and pipe A's if it is 0. `wbk_b_late` plays the same role for the writeback sources.
- R9: A forwarding source whose valid flag is 0 never matches, whatever its destination index.
- R10: Any read port can take its operand from a source of either pipe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_a_en | input | 1 | Pipe A write enable |
| wr_a_idx | input | 5 | Pipe A write index |
| wr_a_data | input | 64 | Pipe A write data |
| wr_b_en | input | 1 | Pipe B write enable |
| wr_b_idx | input | 5 | Pipe B write index |
| wr_b_data | input | 64 | Pipe B write data |
| wr_b_late | input | 1 | 1: pipe B write is later in program order |
| ex_a_vld | input | 1 | Pipe A execute result valid |
| ex_a_dst | input | 5 | Pipe A execute destination |
| ex_a_data | input | 64 | Pipe A execute result |
| ex_b_vld | input | 1 | Pipe B execute result valid |
| ex_b_dst | input | 5 | Pipe B execute destination |
| ex_b_data | input | 64 | Pipe B execute result |
| ex_b_late | input | 1 | 1: pipe B execute op is later |
| wbk_a_vld | input | 1 | Pipe A writeback result valid |
| wbk_a_dst | input | 5 | Pipe A writeback destination |
| wbk_a_data | input | 64 | Pipe A writeback result |
| wbk_b_vld | input | 1 | Pipe B writeback result valid |
| wbk_b_dst | input | 5 | Pipe B writeback destination |
| wbk_b_data | input | 64 | Pipe B writeback result |
| wbk_b_late | input | 1 | 1: pipe B writeback op is later |
| rd_idx | input | 20 | Four packed 5-bit read indices, port 0 in the low bits |
| rd_data | output | 256 | Four packed 64-bit resolved operands, port 0 in the low bits |

## Verification
The assertions check four things on every cycle:
- the reset clearing of the outputs;
- zero on any lane that read index 0;
- that at most one forwarding candidate is selected per port, and only a valid one;
- that writes, including same-register collisions, land with the right data one cycle later.

Other properties can be shown only by the bench's scenarios. These include that the selected producer is the youngest one, the order-bit reversals inside a stage, and the fact that a same-cycle write is bypassed to the reader. They also include that invalid sources with matching indices leave the array value intact, and that values reach any lane from either pipe.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int XLEN = 64;
  localparam int NREG = 32;
  localparam int AW   = $clog2(NREG);
  localparam int NRD  = 4;
  localparam int NSRC = 6;  // two execute, two writeback, two writes

  typedef struct packed {
    logic            vld;
    logic [AW-1:0]   dst;
    logic [XLEN-1:0] data;
  } fwd_src_t;
endpackage

// File: rtl/rf_bank.sv
module rf_bank #(
  parameter int XLEN = 64,
  parameter int NREG = 32,
  parameter int NRD  = 4,
  localparam int AW  = $clog2(NREG)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wa_en,
  input  logic [AW-1:0]       wa_idx,
  input  logic [XLEN-1:0]     wa_data,
  input  logic                wb_en,
  input  logic [AW-1:0]       wb_idx,
  input  logic [XLEN-1:0]     wb_data,
  input  logic                b_late,
  input  logic [NRD*AW-1:0]   rd_idx,
  output logic [NRD*XLEN-1:0] rd_raw
);
  logic [XLEN-1:0] mem [NREG];

  // later nonblocking assignment wins: older port written first
  always_ff @(posedge clk) begin
    if (b_late) begin
      if (wa_en && wa_idx != '0) mem[wa_idx] <= wa_data;
      if (wb_en && wb_idx != '0) mem[wb_idx] <= wb_data;
    end else begin
      if (wb_en && wb_idx != '0) mem[wb_idx] <= wb_data;
      if (wa_en && wa_idx != '0) mem[wa_idx] <= wa_data;
    end
  end

  for (genvar k = 0; k < NRD; k++) begin : g_rd
    assign rd_raw[k*XLEN +: XLEN] = mem[rd_idx[k*AW +: AW]];
  end

  AST_WRITE_A_LANDS: assert property (@(posedge clk) disable iff (rst)
    (wa_en && wa_idx != '0 && !(wb_en && wb_idx == wa_idx && b_late))
    |=> mem[$past(wa_idx)] == $past(wa_data)); // R3

  AST_LATE_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
    (wa_en && wb_en && wa_idx == wb_idx && wb_idx != '0 && b_late)
    |=> mem[$past(wb_idx)] == $past(wb_data)); // R5
endmodule

// File: rtl/rf_fwd_sel.sv
module rf_fwd_sel
  import rf_pkg::*;
#(
  parameter int NS = NSRC
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     idx,
  input  fwd_src_t [NS-1:0] cand,   // index 0 is the youngest
  input  logic [XLEN-1:0]   arr_data,
  output logic [XLEN-1:0]   opnd
);
  logic [NS-1:0] match;
  logic [NS-1:0] pick;

  for (genvar s = 0; s < NS; s++) begin : g_match
    assign match[s] = cand[s].vld && (cand[s].dst == idx);
  end

  always_comb begin
    pick = '0;
    for (int s = NS - 1; s >= 0; s--) begin
      if (match[s]) begin
        pick    = '0;
        pick[s] = 1'b1;
      end
    end
  end

  always_comb begin
    opnd = arr_data;
    for (int s = 0; s < NS; s++) begin
      if (pick[s]) opnd = cand[s].data;
    end
    if (idx == '0) opnd = '0;
  end

  AST_ONE_PRODUCER: assert property (@(posedge clk) disable iff (rst)
    $onehot0(pick)); // R7

  for (genvar s = 0; s < NS; s++) begin : g_chk
    AST_INVALID_IGNORED: assert property (@(posedge clk) disable iff (rst)
      pick[s] |-> cand[s].vld); // R9
  end
endmodule

// File: rtl/dual_rf_bypass.sv
module dual_rf_bypass
  import rf_pkg::*;
#(
  parameter int W   = XLEN,
  parameter int NR  = NRD,
  localparam int IW = AW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_a_en,
  input  logic [IW-1:0]    wr_a_idx,
  input  logic [W-1:0]     wr_a_data,
  input  logic             wr_b_en,
  input  logic [IW-1:0]    wr_b_idx,
  input  logic [W-1:0]     wr_b_data,
  input  logic             wr_b_late,
  input  logic             ex_a_vld,
  input  logic [IW-1:0]    ex_a_dst,
  input  logic [W-1:0]     ex_a_data,
  input  logic             ex_b_vld,
  input  logic [IW-1:0]    ex_b_dst,
  input  logic [W-1:0]     ex_b_data,
  input  logic             ex_b_late,
  input  logic             wbk_a_vld,
  input  logic [IW-1:0]    wbk_a_dst,
  input  logic [W-1:0]     wbk_a_data,
  input  logic             wbk_b_vld,
  input  logic [IW-1:0]    wbk_b_dst,
  input  logic [W-1:0]     wbk_b_data,
  input  logic             wbk_b_late,
  input  logic [NR*IW-1:0] rd_idx,
  output logic [NR*W-1:0]  rd_data
);
  logic [NR*W-1:0] arr_raw;
  logic [NR*W-1:0] resolved;
  fwd_src_t [NSRC-1:0] cand;
  fwd_src_t ex_a, ex_b, wk_a, wk_b, wr_a, wr_b;

  assign ex_a = '{vld: ex_a_vld,  dst: ex_a_dst,  data: ex_a_data};
  assign ex_b = '{vld: ex_b_vld,  dst: ex_b_dst,  data: ex_b_data};
  assign wk_a = '{vld: wbk_a_vld, dst: wbk_a_dst, data: wbk_a_data};
  assign wk_b = '{vld: wbk_b_vld, dst: wbk_b_dst, data: wbk_b_data};
  assign wr_a = '{vld: wr_a_en,   dst: wr_a_idx,  data: wr_a_data};
  assign wr_b = '{vld: wr_b_en,   dst: wr_b_idx,  data: wr_b_data};

  // youngest first: stage order, then program order inside the stage
  assign cand[0] = ex_b_late  ? ex_b : ex_a;
  assign cand[1] = ex_b_late  ? ex_a : ex_b;
  assign cand[2] = wbk_b_late ? wk_b : wk_a;
  assign cand[3] = wbk_b_late ? wk_a : wk_b;
  assign cand[4] = wr_b_late  ? wr_b : wr_a;
  assign cand[5] = wr_b_late  ? wr_a : wr_b;

  rf_bank #(.XLEN(W), .NREG(NREG), .NRD(NR)) i_bank (
    .clk     (clk),
    .rst     (rst),
    .wa_en   (wr_a_en),
    .wa_idx  (wr_a_idx),
    .wa_data (wr_a_data),
    .wb_en   (wr_b_en),
    .wb_idx  (wr_b_idx),
    .wb_data (wr_b_data),
    .b_late  (wr_b_late),
    .rd_idx  (rd_idx),
    .rd_raw  (arr_raw)
  );

  for (genvar k = 0; k < NR; k++) begin : g_port
    rf_fwd_sel #(.NS(NSRC)) i_sel (
      .clk      (clk),
      .rst      (rst),
      .idx      (rd_idx[k*IW +: IW]),
      .cand     (cand),
      .arr_data (arr_raw[k*W +: W]),
      .opnd     (resolved[k*W +: W])
    );

    AST_R0_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(rd_idx[k*IW +: IW]) == '0)
      |-> rd_data[k*W +: W] == '0); // R2
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= resolved;
  end

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> rd_data == '0); // R1
endmodule

// File: tb/test_dual_rf_bypass.sv
module test_dual_rf_bypass;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] D11 = 64'h1111_0000_0000_0011;
  localparam logic [63:0] D22 = 64'h2222_0000_0000_0022;
  localparam logic [63:0] D33 = 64'h3333_0000_0000_0033;
  localparam logic [63:0] D44 = 64'h4444_0000_0000_0044;
  localparam logic [63:0] D55 = 64'h5555_0000_0000_0055;
  localparam logic [63:0] D66 = 64'h6666_0000_0000_0066;
  localparam logic [63:0] D77 = 64'h7777_0000_0000_0077;
  localparam logic [63:0] D88 = 64'h8888_0000_0000_0088;
  localparam logic [63:0] XA  = 64'hEAEA_0000_0000_00A1;
  localparam logic [63:0] XB  = 64'hEBEB_0000_0000_00B1;
  localparam logic [63:0] WA  = 64'hDADA_0000_0000_00A2;
  localparam logic [63:0] WB  = 64'hDBDB_0000_0000_00B2;
  localparam logic [63:0] ZZ  = 64'hCCCC_0000_0000_00CC;
  localparam logic [63:0] JNK = 64'hBAD0_BAD0_BAD0_BAD0;

  typedef struct packed {
    logic        wae; logic [4:0] wai; logic [63:0] wad;
    logic        wbe; logic [4:0] wbi; logic [63:0] wbd;
    logic        late;
    logic [19:0] rdi;
    logic [255:0] exp;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{1'b1, 5'd1, D11, 1'b1, 5'd2, D22, 1'b0,
      {5'd1, 5'd0, 5'd2, 5'd1}, {D11, 64'd0, D22, D11}},
    '{1'b1, 5'd3, D33, 1'b1, 5'd3, D44, 1'b1,
      {5'd2, 5'd1, 5'd3, 5'd3}, {D22, D11, D44, D44}},
    '{1'b1, 5'd3, D55, 1'b1, 5'd3, D66, 1'b0,
      {5'd2, 5'd3, 5'd0, 5'd3}, {D22, D55, 64'd0, D55}},
    '{1'b1, 5'd0, D77, 1'b0, 5'd0, 64'd0, 1'b0,
      {5'd0, 5'd0, 5'd0, 5'd0}, 256'd0},
    '{1'b0, 5'd0, 64'd0, 1'b0, 5'd0, 64'd0, 1'b0,
      {5'd0, 5'd1, 5'd2, 5'd3}, {64'd0, D11, D22, D55}},
    '{1'b0, 5'd0, 64'd0, 1'b1, 5'd4, D88, 1'b0,
      {5'd0, 5'd3, 5'd4, 5'd4}, {64'd0, D55, D88, D88}}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic wr_a_en, wr_b_en, wr_b_late;
  logic [4:0] wr_a_idx, wr_b_idx;
  logic [63:0] wr_a_data, wr_b_data;
  logic ex_a_vld, ex_b_vld, ex_b_late, wbk_a_vld, wbk_b_vld, wbk_b_late;
  logic [4:0] ex_a_dst, ex_b_dst, wbk_a_dst, wbk_b_dst;
  logic [63:0] ex_a_data, ex_b_data, wbk_a_data, wbk_b_data;
  logic [19:0] rd_idx;
  logic [255:0] rd_data;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dual_rf_bypass i_dual_rf_bypass (.*);

  function automatic string vec_tag(int i);
    case (i)
      0: return "R6";
      1: return "R5";
      2: return "R5";
      3: return "R2";
      4: return "R4";
      default: return "R3";
    endcase
  endfunction

  task automatic chk(input logic [63:0] got, input logic [63:0] exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic logic [63:0] lane(int k);
    return rd_data[k*64 +: 64];
  endfunction

  task automatic idle();
    wr_a_en = 0; wr_a_idx = 0; wr_a_data = 0;
    wr_b_en = 0; wr_b_idx = 0; wr_b_data = 0; wr_b_late = 0;
    ex_a_vld = 0; ex_a_dst = 0; ex_a_data = 0;
    ex_b_vld = 0; ex_b_dst = 0; ex_b_data = 0; ex_b_late = 0;
    wbk_a_vld = 0; wbk_a_dst = 0; wbk_a_data = 0;
    wbk_b_vld = 0; wbk_b_dst = 0; wbk_b_data = 0; wbk_b_late = 0;
    rd_idx = 0;
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog got=hung exp=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    idle();
    rd_idx = {5'd1, 5'd2, 5'd3, 5'd4};
    step(); step();
    for (int k = 0; k < 4; k++) chk(lane(k), 64'd0, "R1 reset");
    @(negedge clk); rst = 0;

    // vector walk: writes, collisions, same-cycle reads
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      idle();
      wr_a_en = VEC[i].wae; wr_a_idx = VEC[i].wai; wr_a_data = VEC[i].wad;
      wr_b_en = VEC[i].wbe; wr_b_idx = VEC[i].wbi; wr_b_data = VEC[i].wbd;
      wr_b_late = VEC[i].late; rd_idx = VEC[i].rdi;
      step();
      for (int k = 0; k < 4; k++)
        chk(lane(k), VEC[i].exp[k*64 +: 64], vec_tag(i));
    end

    // execute sources over writeback, pipe B later
    @(negedge clk); idle();
    ex_a_vld = 1; ex_a_dst = 1; ex_a_data = XA;
    ex_b_vld = 1; ex_b_dst = 1; ex_b_data = XB; ex_b_late = 1;
    wbk_a_vld = 1; wbk_a_dst = 1; wbk_a_data = WA;
    rd_idx = {5'd1, 5'd0, 5'd2, 5'd1};
    step();
    chk(lane(0), XB, "R8 ex pipe B later");
    chk(lane(1), D22, "R7 unmatched uses array");
    chk(lane(2), 64'd0, "R2 index zero");
    chk(lane(3), XB, "R10 cross pipe to port3");

    // order bit reversed
    @(negedge clk); ex_b_late = 0;
    step();
    chk(lane(0), XA, "R8 ex pipe A later");

    // writeback over same-cycle write; pipe B source to port 1
    @(negedge clk); idle();
    wbk_a_vld = 1; wbk_a_dst = 1; wbk_a_data = WA;
    wbk_b_vld = 1; wbk_b_dst = 2; wbk_b_data = WB;
    wr_a_en = 1; wr_a_idx = 1; wr_a_data = ZZ;
    rd_idx = {5'd3, 5'd4, 5'd2, 5'd1};
    step();
    chk(lane(0), WA, "R7 writeback over write");
    chk(lane(1), WB, "R10 pipe B writeback");
    chk(lane(2), D88, "R4 port2 array");
    chk(lane(3), D55, "R4 port3 array");

    // invalid sources with matching indices
    @(negedge clk); idle();
    ex_a_dst = 2; ex_a_data = JNK;
    wbk_b_dst = 4; wbk_b_data = JNK;
    rd_idx = {5'd0, 5'd1, 5'd4, 5'd2};
    step();
    chk(lane(0), D22, "R9 invalid ex");
    chk(lane(1), D88, "R9 invalid writeback");
    chk(lane(2), ZZ, "R3 write stored");

    // every source names index 0
    @(negedge clk); idle();
    ex_a_vld = 1; ex_a_data = JNK; ex_b_vld = 1; ex_b_data = JNK;
    wbk_a_vld = 1; wbk_a_data = JNK; wbk_b_vld = 1; wbk_b_data = JNK;
    wr_a_en = 1; wr_a_data = JNK; wr_b_en = 1; wr_b_data = JNK;
    step();
    chk(lane(0), 64'd0, "R2 r0 ignores sources");
    chk(lane(3), 64'd0, "R2 r0 ignores sources");
    @(negedge clk); idle();
    step();
    chk(lane(1), 64'd0, "R2 r0 write dropped");

    // reset mid-run
    @(negedge clk); idle(); rst = 1; rd_idx = {5'd1, 5'd2, 5'd3, 5'd4};
    step();
    chk(rd_data[63:0], 64'd0, "R1 mid-run reset");
    chk(rd_data[255:192], 64'd0, "R1 mid-run reset");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule